// File: doc/BRIEF.md
# Ordered Power-Rail Enable Sequencer

This block decides when two groups of supply rails may be connected to a backplane, and in what order. The first group is a pair of low-voltage rails, one positive and one negative. The second group is a single high-voltage rail. The block reads several inputs, all assumed already synchronous to its clock:

- under-voltage status flags for the logic supply, both low-voltage rails and the high-voltage rail;
- a flag for the AC line;
- two front-panel switch levels;
- three enable bits from the host.

It drives three outputs: an enable for the low rails, an enable for the high rail, and an enable for the analog switches.

The low rails must always be powered before the high rail and removed after it. On power-up, the high rail is connected only after a fixed settling delay. On a fault in any low-rail condition, the high rail is removed at once and the low rails are removed after the same delay. One shared counter times both directions. If only the high-rail conditions are lost, only the high rail is dropped. The delay is 2^(CNT_W+PRE_W) clock cycles. With the default parameters this is 8192 cycles, about 82 ms on a 100 kHz clock.

Top module: `rail_sequencer`

## Requirements
- R1: `rail_lo_on` rises one clock after all six low-rail conditions hold together: `ok_5v`, `ok_pos16`, `ok_neg16`, `ok_ac`, `sw_low` and `host_low_en`, all active high. It stays low while any one of them is low.
- R2: `rail_hi_on` is only ever high while `rail_lo_on` is high. It never rises unless `ok_hv`, `sw_high` and `host_high_en` are also high.
- R3: A front-panel switch only qualifies its rail. With the matching host enable low, no rail turns on, whatever the switch level.
- R4: On power-up, `rail_hi_on` rises exactly DLY+2 clocks after the delay is armed. The delay is armed on the first clock where `rail_lo_on` is high, `rail_hi_on` is low and all high-rail conditions hold. This gives DLY+3 clocks from the low-rail conditions to `rail_hi_on`.
- R5: DLY equals 2^(CNT_W+PRE_W). The defaults CNT_W=6 and PRE_W=7 give 8192 cycles.
- R6: When any low-rail condition drops while `rail_lo_on` is high, `rail_hi_on` falls on the next clock. `rail_lo_on` falls DLY+1 clocks after that.
- R7: When only `ok_hv`, `sw_high` or `host_high_en` drops, `rail_hi_on` falls on the next clock and `rail_lo_on` stays high.
- R8: Once a teardown has started, it runs to completion even if the low-rail conditions come back during the delay.
- R9: If a high-rail condition drops during the power-up delay, the delay is cancelled. When the condition returns, a full new delay of DLY+2 clocks runs.
- R10: `ana_sw_on` is high exactly when both rail enables are high and the analog request is present.
- R11: `ana_bypass` high stands in for `host_ana_req`, so that controllers without the request still get `ana_sw_on`.
- R12: A synchronous active-high `rst` clears both rail enables, the delay state and the counters. Both rails stay off throughout reset.
- R13: After a teardown, `rail_lo_on` can set again no earlier than two clocks after it fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| ok_5v | input | 1 | Logic supply above threshold |
| ok_pos16 | input | 1 | Positive low rail above threshold |
| ok_neg16 | input | 1 | Negative low rail beyond threshold |
| ok_ac | input | 1 | AC line above threshold |
| ok_hv | input | 1 | High-voltage rail above threshold |
| sw_low | input | 1 | Front-panel switch for the low rails |
| sw_high | input | 1 | Front-panel switch for the high rail |
| host_low_en | input | 1 | Host enable for the low rails |
| host_high_en | input | 1 | Host enable for the high rail |
| host_ana_req | input | 1 | Host request for the analog switches |
| ana_bypass | input | 1 | Forces the analog request true |
| rail_lo_on | output | 1 | Connects both low rails |
| rail_hi_on | output | 1 | Connects the high rail |
| ana_sw_on | output | 1 | Enables the analog switches |

## Verification
Most internal faults in this block show up as timing errors at the rail enables, not as wrong levels. A miscounted prescaler or counter moves the edge of `rail_hi_on` on power-up, or of `rail_lo_on` on teardown, by one or more cycles. A stale delay-direction or done flag shows up as a high rail that comes on with no delay, or a low rail that stays on or drops early. The reference model predicts both rail enables and `ana_sw_on` on every clock. A wrong state is therefore reported at the first edge where it alters an output, and at the latest when the delay of the current sequence ends.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

   // Direction of the sequence currently being timed by the shared counter.
   typedef enum logic {
      SEQ_UP   = 1'b0,
      SEQ_DOWN = 1'b1
   } seq_dir_t;

   // Bundle of qualified conditions handed from the qualifier to the control.
   typedef struct packed {
      logic low_ok;
      logic hv_ok;
      logic ana_ok;
   } seq_cond_t;

endpackage

// File: rtl/rail_seq_qualify.sv
module rail_seq_qualify
   import rail_seq_pkg::*;
#(
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic      ok_5v,
   input  logic      ok_pos16,
   input  logic      ok_neg16,
   input  logic      ok_ac,
   input  logic      ok_hv,
   input  logic      sw_low,
   input  logic      sw_high,
   input  logic      host_low_en,
   input  logic      host_high_en,
   input  logic      host_ana_req,
   input  logic      ana_bypass,
   output seq_cond_t cond
);

   localparam int N_LOW = 6;
   localparam int N_HV  = 3;

   logic [N_LOW-1:0] low_vec;
   logic [N_HV-1:0]  hv_vec;

   // Switches qualify the host enables; neither alone is enough.
   assign low_vec = {ok_5v, ok_pos16, ok_neg16, ok_ac, sw_low, host_low_en};
   assign hv_vec  = {ok_hv, sw_high, host_high_en};

   assign cond.low_ok = &low_vec;
   assign cond.hv_ok  = &hv_vec;

   generate
      if (BYPASS_EN) begin : g_bypass
         assign cond.ana_ok = host_ana_req | ana_bypass;
      end else begin : g_nobypass
         logic unused_bypass;
         assign unused_bypass = ana_bypass;
         assign cond.ana_ok   = host_ana_req;
      end
   endgenerate

endmodule

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
   parameter int CNT_W = 6,
   parameter int PRE_W = 7
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic run,
   output logic term
);

   logic             pre_wrap;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (PRE_W > 0) begin : g_pre
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (rst || clr) begin
               pre_q <= '0;
            end else if (run) begin
               pre_q <= pre_q + 1'b1;
            end
         end
         assign pre_wrap = &pre_q;
      end else begin : g_nopre
         assign pre_wrap = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt_q <= '0;
      end else if (run && pre_wrap) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // Terminal count: last cycle of a 2^(CNT_W+PRE_W) cycle run.
   assign term = run & pre_wrap & (&cnt_q);

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
   import rail_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  seq_cond_t cond,
   input  logic      term,
   output logic      tmr_clr,
   output logic      tmr_run,
   output logic      lo_on,
   output logic      hi_on
);

   logic     lo_q, hi_q, run_q, done_q;
   seq_dir_t dir_q;

   logic high_ok, down_busy, start_dn, start_up;

   assign high_ok   = cond.low_ok & cond.hv_ok;
   assign down_busy = (run_q | done_q) & (dir_q == SEQ_DOWN);
   // Fault in any low-rail condition: begin reverse-order teardown.
   assign start_dn  = ~cond.low_ok & lo_q & ~down_busy;
   // Low rails settled and high conditions present: arm the up delay.
   assign start_up  = lo_q & ~hi_q & high_ok & ~run_q & ~done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q   <= 1'b0;
         hi_q   <= 1'b0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
         dir_q  <= SEQ_UP;
      end else if (start_dn) begin
         hi_q   <= 1'b0;
         run_q  <= 1'b1;
         done_q <= 1'b0;
         dir_q  <= SEQ_DOWN;
      end else begin
         if (~high_ok && hi_q) begin
            hi_q <= 1'b0;
         end
         if (run_q) begin
            if ((dir_q == SEQ_UP) && ~high_ok) begin
               run_q <= 1'b0;
            end else if (term) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end else if (done_q) begin
            if (lo_q == hi_q) begin
               done_q <= 1'b0;
            end else if (dir_q == SEQ_DOWN) begin
               lo_q <= 1'b0;
            end else if (~high_ok) begin
               done_q <= 1'b0;
            end else begin
               hi_q <= 1'b1;
            end
         end else if (start_up) begin
            run_q <= 1'b1;
            dir_q <= SEQ_UP;
         end
         if (~lo_q && cond.low_ok && ~run_q && ~done_q) begin
            lo_q <= 1'b1;
         end
      end
   end

   assign tmr_clr = start_dn | start_up;
   assign tmr_run = run_q;
   assign lo_on   = lo_q;
   assign hi_on   = hi_q;

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
   import rail_seq_pkg::*;
#(
   parameter int CNT_W     = 6,
   parameter int PRE_W     = 7,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic ok_5v,
   input  logic ok_pos16,
   input  logic ok_neg16,
   input  logic ok_ac,
   input  logic ok_hv,
   input  logic sw_low,
   input  logic sw_high,
   input  logic host_low_en,
   input  logic host_high_en,
   input  logic host_ana_req,
   input  logic ana_bypass,
   output logic rail_lo_on,
   output logic rail_hi_on,
   output logic ana_sw_on
);

   localparam int TOT_W = CNT_W + PRE_W;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("rail_sequencer: CNT_W must be at least 1");
      end
      if (PRE_W < 0) begin : g_bad_pre
         $error("rail_sequencer: PRE_W must not be negative");
      end
      if (TOT_W > 30) begin : g_bad_tot
         $error("rail_sequencer: CNT_W+PRE_W too large");
      end
   endgenerate

   seq_cond_t cond;
   logic      tmr_clr, tmr_run, term;

   rail_seq_qualify #(.BYPASS_EN(BYPASS_EN)) u_qual (
      .ok_5v        (ok_5v),
      .ok_pos16     (ok_pos16),
      .ok_neg16     (ok_neg16),
      .ok_ac        (ok_ac),
      .ok_hv        (ok_hv),
      .sw_low       (sw_low),
      .sw_high      (sw_high),
      .host_low_en  (host_low_en),
      .host_high_en (host_high_en),
      .host_ana_req (host_ana_req),
      .ana_bypass   (ana_bypass),
      .cond         (cond)
   );

   rail_seq_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .clr  (tmr_clr),
      .run  (tmr_run),
      .term (term)
   );

   rail_seq_ctrl u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .cond    (cond),
      .term    (term),
      .tmr_clr (tmr_clr),
      .tmr_run (tmr_run),
      .lo_on   (rail_lo_on),
      .hi_on   (rail_hi_on)
   );

   assign ana_sw_on = rail_lo_on & rail_hi_on & cond.ana_ok;

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
   parameter int CNT_W = 6,
   parameter int PRE_W = 7
) (
   input logic clk,
   input logic rst,
   input logic ok_5v,
   input logic ok_pos16,
   input logic ok_neg16,
   input logic ok_ac,
   input logic ok_hv,
   input logic sw_low,
   input logic sw_high,
   input logic host_low_en,
   input logic host_high_en,
   input logic host_ana_req,
   input logic ana_bypass,
   input logic rail_lo_on,
   input logic rail_hi_on,
   input logic ana_sw_on
);

   localparam int DLY = 1 << (CNT_W + PRE_W);

   logic all_low, all_hv;
   int   lo_age, hi_off_age;

   assign all_low = ok_5v & ok_pos16 & ok_neg16 & ok_ac & sw_low & host_low_en;
   assign all_hv  = ok_hv & sw_high & host_high_en;

   // Window counters for the delay checks (depth comes from parameters).
   always_ff @(posedge clk) begin
      if (rst || !rail_lo_on) lo_age <= 0;
      else if (lo_age < DLY + 8) lo_age <= lo_age + 1;
      if (rst || rail_hi_on) hi_off_age <= 0;
      else if (hi_off_age < DLY + 8) hi_off_age <= hi_off_age + 1;
   end

   assert_low_cond_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(rail_lo_on) |-> $past(all_low));

   assert_hi_needs_lo_R2: assert property (@(posedge clk) disable iff (rst)
      rail_hi_on |-> rail_lo_on);

   assert_hi_cond_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(rail_hi_on) |-> ($past(host_high_en) && $past(sw_high) && $past(ok_hv)));

   assert_up_delay_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(rail_hi_on) |-> (lo_age >= DLY + 2));

   assert_down_delay_R6: assert property (@(posedge clk) disable iff (rst)
      ($fell(rail_lo_on) && !$past(rst)) |-> (hi_off_age >= DLY + 1));

   assert_hv_only_drop_R7: assert property (@(posedge clk) disable iff (rst)
      (rail_hi_on && all_low && !all_hv) |=> (!rail_hi_on && rail_lo_on));

   assert_order_down_R6: assert property (@(posedge clk) disable iff (rst)
      ($fell(rail_lo_on) && !$past(rst)) |-> !$past(rail_hi_on));

   assert_ana_R10: assert property (@(posedge clk) disable iff (rst)
      ana_sw_on |-> (rail_lo_on && rail_hi_on && (host_ana_req || ana_bypass)));

   assert_ana_on_R11: assert property (@(posedge clk) disable iff (rst)
      (rail_lo_on && rail_hi_on && ana_bypass) |-> ana_sw_on);

endmodule

bind rail_sequencer rail_seq_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .ok_5v        (ok_5v),
   .ok_pos16     (ok_pos16),
   .ok_neg16     (ok_neg16),
   .ok_ac        (ok_ac),
   .ok_hv        (ok_hv),
   .sw_low       (sw_low),
   .sw_high      (sw_high),
   .host_low_en  (host_low_en),
   .host_high_en (host_high_en),
   .host_ana_req (host_ana_req),
   .ana_bypass   (ana_bypass),
   .rail_lo_on   (rail_lo_on),
   .rail_hi_on   (rail_hi_on),
   .ana_sw_on    (ana_sw_on)
);

// File: tb/tb_rail_sequencer.sv
module tb_rail_sequencer;

   localparam int CNT_W = 3;
   localparam int PRE_W = 2;
   localparam int DLY   = 1 << (CNT_W + PRE_W);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ok_5v = 0, ok_pos16 = 0, ok_neg16 = 0, ok_ac = 0, ok_hv = 0;
   logic sw_low = 0, sw_high = 0, host_low_en = 0, host_high_en = 0;
   logic host_ana_req = 0, ana_bypass = 0;
   logic rail_lo_on, rail_hi_on, ana_sw_on;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit started = 0;

   always #10 clk = ~clk;

   rail_sequencer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) dut (
      .clk(clk), .rst(rst), .ok_5v(ok_5v), .ok_pos16(ok_pos16),
      .ok_neg16(ok_neg16), .ok_ac(ok_ac), .ok_hv(ok_hv), .sw_low(sw_low),
      .sw_high(sw_high), .host_low_en(host_low_en), .host_high_en(host_high_en),
      .host_ana_req(host_ana_req), .ana_bypass(ana_bypass),
      .rail_lo_on(rail_lo_on), .rail_hi_on(rail_hi_on), .ana_sw_on(ana_sw_on));

   // Behavioural reference: rail levels, a phase number and a cycle timer.
   // phase 0 idle, 1 up delay, 2 up done, 3 down delay, 4 down done,
   // 5 teardown settle, 6 up settle
   int m_lo = 0, m_hi = 0, m_ph = 0, m_t = 0;

   function automatic int m_ana();
      return (m_lo && m_hi && (host_ana_req || ana_bypass)) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      int lok, hok, nlo, nhi, nph, nt;
      started = 1;
      lok = (ok_5v && ok_pos16 && ok_neg16 && ok_ac && sw_low && host_low_en) ? 1 : 0;
      hok = (lok && ok_hv && sw_high && host_high_en) ? 1 : 0;
      nlo = m_lo; nhi = m_hi; nph = m_ph; nt = m_t;
      if (rst) begin
         nlo = 0; nhi = 0; nph = 0; nt = 0;
      end else if (!lok && m_lo && m_ph != 3 && m_ph != 4) begin
         nhi = 0; nph = 3; nt = 0;
      end else begin
         if (!hok && m_hi) nhi = 0;
         case (m_ph)
            1: if (!hok) nph = 0; else if (m_t == DLY - 1) nph = 2; else nt = m_t + 1;
            2: if (hok) begin nhi = 1; nph = 6; end else nph = 0;
            3: if (m_t == DLY - 1) nph = 4; else nt = m_t + 1;
            4: begin nlo = 0; nph = 5; end
            5: nph = 0;
            6: nph = 0;
            default: begin
               if (m_lo && !m_hi && hok) begin nph = 1; nt = 0; end
               if (!m_lo && lok) nlo = 1;
            end
         endcase
      end
      m_lo = nlo; m_hi = nhi; m_ph = nph; m_t = nt;
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         failures++;
         $display("FAIL R4 watchdog: cycles=%0d expected below %0d", cyc, 20000);
         finish_run();
      end
   end

   // Per-cycle comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (started) begin
         checks++;
         if ({rail_lo_on, rail_hi_on, ana_sw_on} !==
             {m_lo[0], m_hi[0], 1'(m_ana())}) begin
            failures++;
            $display("FAIL R1/R4/R10 model cycle %0d: lo,hi,ana actual=%b%b%b expected=%0d%0d%0d",
                     cyc, rail_lo_on, rail_hi_on, ana_sw_on, m_lo, m_hi, m_ana());
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #3;
   endtask

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   initial begin
      step(3);
      chk(rail_lo_on, 1'b0, "R12 lo in reset");
      chk(rail_hi_on, 1'b0, "R12 hi in reset");
      ok_5v = 1; ok_pos16 = 1; ok_neg16 = 1; ok_ac = 1; ok_hv = 1;
      sw_low = 1; sw_high = 1;
      step(2);
      chk(rail_lo_on, 1'b0, "R12 lo held by reset");
      rst = 0;
      step(5);
      chk(rail_lo_on, 1'b0, "R3 switch on, host low off");
      host_low_en = 1; sw_low = 0;
      step(5);
      chk(rail_lo_on, 1'b0, "R1 switch off");
      sw_low = 1;
      step(1);
      chk(rail_lo_on, 1'b1, "R1 low rails on");
      step(DLY + 10);
      chk(rail_hi_on, 1'b0, "R3 high switch on, host high off");
      chk(ana_sw_on, 1'b0, "R2 no high rail");
      host_high_en = 1;
      step(DLY + 1);
      chk(rail_hi_on, 1'b0, "R4 high before delay end");
      step(1);
      chk(rail_hi_on, 1'b1, "R5 high after DLY+2");
      #1 chk(ana_sw_on, 1'b0, "R10 no request");
      host_ana_req = 1;
      #1 chk(ana_sw_on, 1'b1, "R10 request");
      host_ana_req = 0; ana_bypass = 1;
      #1 chk(ana_sw_on, 1'b1, "R11 bypass");
      sw_high = 0;
      step(1);
      chk(rail_hi_on, 1'b0, "R7 high off");
      chk(rail_lo_on, 1'b1, "R7 low kept");
      step(DLY + 5);
      chk(rail_lo_on, 1'b1, "R7 low still kept");
      sw_high = 1;
      step(DLY + 1);
      chk(rail_hi_on, 1'b0, "R4 re-up early");
      step(1);
      chk(rail_hi_on, 1'b1, "R4 re-up");
      ok_ac = 0;
      step(1);
      chk(rail_hi_on, 1'b0, "R6 high drops first");
      chk(rail_lo_on, 1'b1, "R6 low waits");
      ok_ac = 1;
      step(DLY);
      chk(rail_lo_on, 1'b1, "R8 teardown still timing");
      step(1);
      chk(rail_lo_on, 1'b0, "R6 R8 low off after delay");
      step(1);
      chk(rail_lo_on, 1'b0, "R13 no early re-enable");
      step(1);
      chk(rail_lo_on, 1'b1, "R13 re-enable");
      step(10);
      host_high_en = 0;
      step(2);
      chk(rail_hi_on, 1'b0, "R9 aborted");
      host_high_en = 1;
      step(DLY + 1);
      chk(rail_hi_on, 1'b0, "R9 full delay reruns");
      step(1);
      chk(rail_hi_on, 1'b1, "R9 high after restart");
      rst = 1;
      step(1);
      chk(rail_lo_on, 1'b0, "R12 reset clears lo");
      chk(rail_hi_on, 1'b0, "R12 reset clears hi");
      rst = 0;
      step(3);
      finish_run();
   end

endmodule